// File: doc/BRIEF.md
# Multi-Slot PCM Voice Port

This block carries voice samples between on-chip sample registers and external codecs over a four-wire serial bus: a bit clock, a frame sync at the 8 kHz frame rate, and two data lines. It can run as the bus master, generating clock and sync from the system clock by a programmable divider, or as a slave, taking clock and sync from the bus and aligning its bit count to the incoming frames. Master operation is selected when the mode input is low.

Up to three timeslots share one frame. Each slot has an enable, a start bit position inside the frame and a width: a 16-bit word for linear samples of 13 to 16 bits, left-justified, or an 8-bit word for companded samples. Every slot shifts its transmit word out MSB first, shifts its receive word in MSB first, raises a one-cycle done strobe when its last bit has been sampled, and has its own sync output that marks its first bit so that several codecs can share the bus. Each of the two data lines is set to drive or to listen by a configuration bit.

Output data changes shortly after the rising edge of the bus clock and input data is sampled at the falling edge. Compression, expansion and any coding of the samples are left to the surrounding logic.

Top module: `pcm_voice_port`

## Requirements
- R1: While reset is held, the bus clock, frame sync, data lines, data line enables, slot sync outputs, done strobes and receive words are all 0, and the clock and sync enables are 1.
- R2: In master mode (cfg_slave = 0) pcm_clk_out starts low after reset and toggles every HALF_DIV system clock cycles; pcm_clk_oe and pcm_sync_oe are 1.
- R3: In master mode the first rising edge of pcm_clk_out after reset begins frame bit 0, bits advance on each rising edge and wrap after FRAME_BITS bits, and pcm_sync_out is high from the rising edge that begins bit 0 up to the rising edge that begins bit 1.
- R4: An enabled slot with start position s and width W (W = 16 when its wide bit is 1, else 8) sends bits W-1 down to 0 of its transmit word during frame bits s to s+W-1; an 8-bit slot sends bits 7..0. A data line changes two system clock cycles after the rising bus clock edge that begins the bit.
- R5: Outside all enabled slot windows, and for disabled slots, the data lines carry 0.
- R6: pcm_data_oe follows cfg_line_out one cycle later; a line whose bit is 1 carries the serial stream, a line whose bit is 0 carries 0.
- R7: Received bits come from line 0 when cfg_line_out[0] is 0, otherwise from line 1; they are sampled on the falling bus clock edge and assembled MSB first. A 16-bit slot yields the whole word, an 8-bit slot yields the value in bits 7..0 with upper bits 0. The word appears with the done strobe; when both lines drive, the receive word keeps its value.
- R8: slot_done[k] is high for exactly one system clock cycle, one cycle after the falling bus clock edge inside the slot's last bit.
- R9: slot_sync_out[k] of an enabled slot is high for the slot's first bit, with the same two-cycle delay after the rising edge as the data lines.
- R10: When enabled slot windows overlap, the lowest-numbered slot drives the data lines.
- R11: In slave mode (cfg_slave = 1) clock and sync enables are 0; the block detects a frame start at a falling bus clock edge where sync is high after having been low at the previous falling edge, takes that bit as bit 0, keeps all slots idle until the first such frame start, and then sends and receives as in R4 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slave | input | 1 | 0: bus master, 1: bus slave |
| cfg_line_out | input | 2 | Per data line: 1 drive, 0 listen |
| cfg_slot_en | input | NSLOT | Slot enables |
| cfg_slot_wide | input | NSLOT | Per slot: 1 for 16-bit word, 0 for 8-bit word |
| cfg_slot_start | input | NSLOT*POS_W | Per slot first bit position in the frame |
| tx_sample | input | NSLOT*16 | Per slot transmit word |
| rx_sample | output | NSLOT*16 | Per slot last received word |
| slot_done | output | NSLOT | Per slot one-cycle completion strobe |
| pcm_clk_in | input | 1 | Bus clock in slave mode |
| pcm_sync_in | input | 1 | Frame sync in slave mode |
| pcm_data_in | input | 2 | Data line input values |
| pcm_clk_out | output | 1 | Bus clock in master mode |
| pcm_clk_oe | output | 1 | Bus clock drive enable |
| pcm_sync_out | output | 1 | Frame sync in master mode |
| pcm_sync_oe | output | 1 | Frame sync drive enable |
| pcm_data_out | output | 2 | Data line output values |
| pcm_data_oe | output | 2 | Data line drive enables |
| slot_sync_out | output | NSLOT | Per slot first-bit marker |

## Verification
The hardest situation to reach is slave alignment from an arbitrary phase: after reset the block's bit count is unrelated to the bus, so the bench starts its external clock in the middle of a frame with sync low, confirms that no slot drives during those bits even though the internal count passes a slot's start position, and only then raises sync for bit 0. A second awkward case is overlapping windows, which the bench produces by configuring a 16-bit slot and an 8-bit slot that share eight bit positions, so that priority and the continued receive of the hidden slot are both visible. Master phases use a per-cycle model of clock, sync, lines and strobes.

// File: rtl/pcm_voice_pkg.sv
package pcm_voice_pkg;
  localparam int SAMPLE_W = 16;
  localparam int NARROW_W = 8;

  typedef enum logic {
    ROLE_MASTER = 1'b0,
    ROLE_SLAVE  = 1'b1
  } pcm_role_e;

  function automatic logic [4:0] last_bit_of(input logic wide);
    return wide ? 5'(SAMPLE_W - 1) : 5'(NARROW_W - 1);
  endfunction
endpackage

// File: rtl/pcm_sync2.sv
module pcm_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pcm_bit_timer.sv
module pcm_bit_timer
  import pcm_voice_pkg::*;
#(
  parameter int HALF_DIV   = 12,
  parameter int FRAME_BITS = 256,
  localparam int POS_W     = $clog2(FRAME_BITS),
  localparam int DW        = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slave,
  input  logic             ext_clk,
  input  logic             ext_sync,
  output logic             rise_ev,
  output logic             fall_ev,
  output logic [POS_W-1:0] bit_idx,
  output logic             locked,
  output logic             clk_out,
  output logic             sync_out
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [DW-1:0]    DIV_TOP  = DW'(HALF_DIV - 1);

  pcm_role_e        role;
  logic [1:0]       ext_s;
  logic [DW-1:0]    div_q;
  logic             ext_clk_d_q;
  logic             sync_seen_q;
  logic             m_tick, m_rise, m_fall, s_rise, s_fall;
  logic             rise_now, fall_now, frame_mark;
  logic [POS_W-1:0] bit_next;

  pcm_sync2 #(.W(2)) u_in_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ext_sync, ext_clk}),
    .q   (ext_s)
  );

  always_comb begin
    role       = pcm_role_e'(slave);
    m_tick     = (div_q == DIV_TOP);
    m_rise     = m_tick & ~clk_out;
    m_fall     = m_tick & clk_out;
    s_rise     = ext_s[0] & ~ext_clk_d_q;
    s_fall     = ~ext_s[0] & ext_clk_d_q;
    rise_now   = (role == ROLE_SLAVE) ? s_rise : m_rise;
    fall_now   = (role == ROLE_SLAVE) ? s_fall : m_fall;
    frame_mark = (role == ROLE_SLAVE) & s_fall & ext_s[1] & ~sync_seen_q;
    bit_next   = (bit_idx == LAST_POS) ? '0 : bit_idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q       <= '0;
      clk_out     <= 1'b0;
      sync_out    <= 1'b0;
      bit_idx     <= LAST_POS;
      rise_ev     <= 1'b0;
      fall_ev     <= 1'b0;
      locked      <= 1'b0;
      ext_clk_d_q <= 1'b0;
      sync_seen_q <= 1'b0;
    end else begin
      rise_ev     <= rise_now;
      fall_ev     <= fall_now;
      ext_clk_d_q <= ext_s[0];
      if (role == ROLE_MASTER) begin
        div_q  <= m_tick ? '0 : div_q + 1'b1;
        locked <= 1'b1;
        if (m_tick) clk_out <= ~clk_out;
        if (m_rise) sync_out <= (bit_next == '0);
      end else begin
        div_q    <= '0;
        clk_out  <= 1'b0;
        sync_out <= 1'b0;
        if (frame_mark) locked <= 1'b1;
      end
      if (rise_now)        bit_idx <= bit_next;
      else if (frame_mark) bit_idx <= '0;
      if ((role == ROLE_SLAVE) && s_fall) sync_seen_q <= ext_s[1];
    end
  end

  assert_rise_clk_high_R2: assert property (@(posedge clk) disable iff (rst)
    (!slave && rise_ev) |-> clk_out);
  assert_fall_clk_low_R2: assert property (@(posedge clk) disable iff (rst)
    (!slave && fall_ev) |-> !clk_out);
  assert_sync_bit0_R3: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> (bit_idx == '0));
endmodule

// File: rtl/pcm_slot_unit.sv
module pcm_slot_unit
  import pcm_voice_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rise_ev,
  input  logic                fall_ev,
  input  logic [POS_W-1:0]    bit_idx,
  input  logic                locked,
  input  logic                en,
  input  logic                wide,
  input  logic [POS_W-1:0]    start,
  input  logic [SAMPLE_W-1:0] tx_word,
  input  logic                rx_bit,
  input  logic                rx_ok,
  output logic                drive,
  output logic                tx_bit,
  output logic                slot_sync,
  output logic                done,
  output logic [SAMPLE_W-1:0] rx_word
);
  logic                busy_q;
  logic [4:0]          cnt_q;
  logic [SAMPLE_W-1:0] tx_sh_q;
  logic [SAMPLE_W-1:0] rx_sh_q;
  logic [SAMPLE_W-1:0] rx_full;
  logic [4:0]          last;
  logic                start_hit;

  always_comb begin
    last      = last_bit_of(wide);
    start_hit = rise_ev & locked & en & (bit_idx == start);
    rx_full   = {rx_sh_q[SAMPLE_W-2:0], rx_bit};
    tx_bit    = tx_sh_q[SAMPLE_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      drive     <= 1'b0;
      slot_sync <= 1'b0;
      done      <= 1'b0;
      rx_word   <= '0;
    end else begin
      done <= 1'b0;
      if (start_hit) begin
        busy_q    <= 1'b1;
        cnt_q     <= '0;
        drive     <= 1'b1;
        slot_sync <= 1'b1;
        tx_sh_q   <= wide ? tx_word : {tx_word[NARROW_W-1:0], {(SAMPLE_W-NARROW_W){1'b0}}};
      end else if (rise_ev) begin
        slot_sync <= 1'b0;
        if (busy_q) begin
          cnt_q   <= cnt_q + 1'b1;
          tx_sh_q <= {tx_sh_q[SAMPLE_W-2:0], 1'b0};
        end else begin
          drive <= 1'b0;
        end
      end
      if (fall_ev && busy_q) begin
        rx_sh_q <= rx_full;
        if (cnt_q == last) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
          if (rx_ok)
            rx_word <= wide ? rx_full : {{(SAMPLE_W-NARROW_W){1'b0}}, rx_full[NARROW_W-1:0]};
        end
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_count_range_R4: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q <= last));
  assert_drive_busy_R5: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> drive);
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_voice_pkg::*;
#(
  parameter int HALF_DIV   = 12,
  parameter int FRAME_BITS = 256,
  parameter int NSLOT      = 3,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_slave,
  input  logic [1:0]                cfg_line_out,
  input  logic [NSLOT-1:0]          cfg_slot_en,
  input  logic [NSLOT-1:0]          cfg_slot_wide,
  input  logic [NSLOT*POS_W-1:0]    cfg_slot_start,
  input  logic [NSLOT*SAMPLE_W-1:0] tx_sample,
  output logic [NSLOT*SAMPLE_W-1:0] rx_sample,
  output logic [NSLOT-1:0]          slot_done,
  input  logic                      pcm_clk_in,
  input  logic                      pcm_sync_in,
  input  logic [1:0]                pcm_data_in,
  output logic                      pcm_clk_out,
  output logic                      pcm_clk_oe,
  output logic                      pcm_sync_out,
  output logic                      pcm_sync_oe,
  output logic [1:0]                pcm_data_out,
  output logic [1:0]                pcm_data_oe,
  output logic [NSLOT-1:0]          slot_sync_out
);
  logic             rise_ev, fall_ev, locked;
  logic [POS_W-1:0] bit_idx;
  logic [NSLOT-1:0] drv, txb, ssync;
  logic             rx_bit, rx_ok, any_drv, line_bit;

  pcm_bit_timer #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .slave    (cfg_slave),
    .ext_clk  (pcm_clk_in),
    .ext_sync (pcm_sync_in),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .bit_idx  (bit_idx),
    .locked   (locked),
    .clk_out  (pcm_clk_out),
    .sync_out (pcm_sync_out)
  );

  always_comb begin
    rx_bit = cfg_line_out[0] ? pcm_data_in[1] : pcm_data_in[0];
    rx_ok  = ~&cfg_line_out;
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    pcm_slot_unit #(.FRAME_BITS(FRAME_BITS)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .rise_ev   (rise_ev),
      .fall_ev   (fall_ev),
      .bit_idx   (bit_idx),
      .locked    (locked),
      .en        (cfg_slot_en[k]),
      .wide      (cfg_slot_wide[k]),
      .start     (cfg_slot_start[k*POS_W +: POS_W]),
      .tx_word   (tx_sample[k*SAMPLE_W +: SAMPLE_W]),
      .rx_bit    (rx_bit),
      .rx_ok     (rx_ok),
      .drive     (drv[k]),
      .tx_bit    (txb[k]),
      .slot_sync (ssync[k]),
      .done      (slot_done[k]),
      .rx_word   (rx_sample[k*SAMPLE_W +: SAMPLE_W])
    );
  end

  always_comb begin
    any_drv  = 1'b0;
    line_bit = 1'b0;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (drv[k]) begin
        any_drv  = 1'b1;
        line_bit = txb[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcm_data_out  <= '0;
      pcm_data_oe   <= '0;
      slot_sync_out <= '0;
      pcm_clk_oe    <= 1'b1;
      pcm_sync_oe   <= 1'b1;
    end else begin
      pcm_data_out  <= {2{any_drv & line_bit}} & cfg_line_out;
      pcm_data_oe   <= cfg_line_out;
      slot_sync_out <= ssync;
      pcm_clk_oe    <= ~cfg_slave;
      pcm_sync_oe   <= ~cfg_slave;
    end
  end

  assert_oe_follows_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pcm_data_oe == $past(cfg_line_out)));
endmodule

// File: tb/test_pcm_voice_port.sv
module test_pcm_voice_port;
  localparam int HALF  = 3;
  localparam int FRAME = 32;
  localparam int NS    = 3;
  localparam int PW    = 5;
  localparam int SH    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_slave = 1'b0;
  logic [1:0] cfg_line_out = 2'b01;
  logic [NS-1:0] cfg_slot_en, cfg_slot_wide, slot_done, slot_sync_out;
  logic [NS*PW-1:0] cfg_slot_start;
  logic [NS*16-1:0] tx_sample, rx_sample;
  logic pcm_clk_in = 1'b0, pcm_sync_in = 1'b0;
  logic [1:0] pcm_data_in, din_m = 2'b00, din_s = 2'b00;
  logic pcm_clk_out, pcm_clk_oe, pcm_sync_out, pcm_sync_oe;
  logic [1:0] pcm_data_out, pcm_data_oe;
  logic slave_phase = 1'b0;
  logic mon_on = 1'b0;

  int st[NS];
  logic wd[NS];
  logic en[NS];
  logic [15:0] txw[NS];
  logic [15:0] exp_rx[NS];
  logic [31:0] pat;
  int e = 0;
  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NS; k++) begin
      cfg_slot_en[k]             = en[k];
      cfg_slot_wide[k]           = wd[k];
      cfg_slot_start[k*PW +: PW] = PW'(st[k]);
      tx_sample[k*16 +: 16]      = txw[k];
    end
    pcm_data_in = slave_phase ? din_s : din_m;
  end

  pcm_voice_port #(.HALF_DIV(HALF), .FRAME_BITS(FRAME), .NSLOT(NS)) i_pcm_voice_port (
    .clk(clk), .rst(rst), .cfg_slave(cfg_slave), .cfg_line_out(cfg_line_out),
    .cfg_slot_en(cfg_slot_en), .cfg_slot_wide(cfg_slot_wide), .cfg_slot_start(cfg_slot_start),
    .tx_sample(tx_sample), .rx_sample(rx_sample), .slot_done(slot_done),
    .pcm_clk_in(pcm_clk_in), .pcm_sync_in(pcm_sync_in), .pcm_data_in(pcm_data_in),
    .pcm_clk_out(pcm_clk_out), .pcm_clk_oe(pcm_clk_oe), .pcm_sync_out(pcm_sync_out),
    .pcm_sync_oe(pcm_sync_oe), .pcm_data_out(pcm_data_out), .pcm_data_oe(pcm_data_oe),
    .slot_sync_out(slot_sync_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at edge %0d: actual %0h expected %0h", req, e, act, expv);
    end
  endtask

  function automatic int wlen(input int k);
    return wd[k] ? 16 : 8;
  endfunction

  function automatic int rises_by(input int k);
    if (k < 1) return 0;
    return ((k / HALF) + 1) / 2;
  endfunction

  function automatic int bit_at(input int k);
    int r = rises_by(k);
    return (r == 0) ? -1 : (r - 1) % FRAME;
  endfunction

  function automatic bit is_fall(input int k);
    return (k > 0) && (k % HALF == 0) && ((k / HALF) % 2 == 0);
  endfunction

  function automatic logic [15:0] win(input logic [31:0] p, input int s, input int w, input bit inv);
    logic [15:0] r = '0;
    for (int j = 0; j < w; j++) r = {r[14:0], p[31-(s+j)] ^ inv};
    return r;
  endfunction

  // serial value on the lines for frame bit b, lowest slot wins; hits = windows covering b
  function automatic logic tx_val(input int b, output int hits);
    logic v = 1'b0;
    hits = 0;
    for (int k = NS - 1; k >= 0; k--) begin
      if (en[k] && b >= st[k] && b < st[k] + wlen(k)) begin
        hits++;
        v = txw[k][wlen(k) - 1 - (b - st[k])];
      end
    end
    return v;
  endfunction

  // per-cycle reference comparison in master phases
  always @(posedge clk) begin
    if (rst) e <= 0;
    else     e <= e + 1;
  end

  always @(negedge clk) begin
    if (mon_on && !rst) begin
      int p, b2, bf, bc, hits;
      logic v;
      logic [1:0] dexp;
      logic [NS-1:0] sexp, dnexp;
      p = e / HALF;
      check(pcm_clk_out == p[0] && pcm_clk_oe && pcm_sync_oe, "R2", {pcm_clk_oe, pcm_clk_out}, {1'b1, p[0]});
      check(pcm_sync_out == (bit_at(e) == 0), "R3", pcm_sync_out, bit_at(e) == 0);
      b2 = (e >= 2) ? bit_at(e - 2) : -1;
      v = (b2 < 0) ? 1'b0 : tx_val(b2, hits);
      if (b2 < 0) hits = 0;
      dexp = {2{v}} & cfg_line_out;
      if (e >= 1) check(pcm_data_oe == cfg_line_out, "R6", pcm_data_oe, cfg_line_out);
      for (int l = 0; l < 2; l++)
        if (!cfg_line_out[l]) check(pcm_data_out[l] == 1'b0, "R6", pcm_data_out[l], 0);
      if (hits > 1)       check(pcm_data_out == dexp, "R10", pcm_data_out, dexp);
      else if (hits == 1) check(pcm_data_out == dexp, "R4", pcm_data_out, dexp);
      else                check(pcm_data_out == dexp, "R5", pcm_data_out, dexp);
      bf = is_fall(e - 1) ? bit_at(e - 1) : -1;
      for (int k = 0; k < NS; k++) begin
        sexp[k]  = en[k] && (b2 >= 0) && (b2 == st[k]);
        dnexp[k] = en[k] && (bf >= 0) && (bf == st[k] + wlen(k) - 1);
        if (dnexp[k] && !(&cfg_line_out))
          exp_rx[k] = win(pat, st[k], wlen(k), cfg_line_out[0]);
      end
      check(slot_sync_out == sexp, "R9", slot_sync_out, sexp);
      check(slot_done == dnexp, "R8", slot_done, dnexp);
      for (int k = 0; k < NS; k++)
        check(rx_sample[k*16 +: 16] == exp_rx[k], "R7", rx_sample[k*16 +: 16], exp_rx[k]);
      bc = bit_at(e);
      din_m = (bc < 0) ? 2'b00 : {~pat[31-bc], pat[31-bc]};
    end
  end

  task automatic reset_and_check(input bit master);
    rst = 1'b1;
    mon_on = 1'b0;
    din_m = 2'b00;
    for (int k = 0; k < NS; k++) exp_rx[k] = '0;
    repeat (3) @(negedge clk);
    check(pcm_clk_out == 0 && pcm_sync_out == 0 && pcm_data_out == 0 && pcm_data_oe == 0,
          "R1", {pcm_clk_out, pcm_sync_out, pcm_data_out, pcm_data_oe}, 0);
    check(slot_done == 0 && slot_sync_out == 0 && rx_sample == 0, "R1",
          {slot_done, slot_sync_out}, 0);
    check(pcm_clk_oe && pcm_sync_oe, "R1", {pcm_clk_oe, pcm_sync_oe}, 2'b11);
    rst = 1'b0;
    if (master) mon_on = 1'b1;
  endtask

  task automatic run_master(input int frames);
    reset_and_check(1'b1);
    repeat (frames * FRAME * 2 * HALF) @(negedge clk);
    mon_on = 1'b0;
  endtask

  task automatic slave_bit(input int b, input int fidx);
    int hits;
    logic v;
    @(negedge clk);
    pcm_clk_in  = 1'b1;
    pcm_sync_in = (b == 0) && (fidx >= 0);
    din_s       = {~pat[31-b], pat[31-b]};
    repeat (SH) @(negedge clk);
    pcm_clk_in = 1'b0;
    repeat (SH - 1) @(negedge clk);
    if (fidx < 0) begin
      check(pcm_data_out == 2'b00, "R11", pcm_data_out, 0);
    end else begin
      v = tx_val(b, hits);
      check(pcm_data_out == {1'b0, v}, "R11", pcm_data_out, {1'b0, v});
    end
  endtask

  initial begin
    for (int k = 0; k < NS; k++) begin
      st[k] = 0; wd[k] = 1'b0; en[k] = 1'b0; txw[k] = '0; exp_rx[k] = '0;
    end
    pat = 32'hC5A3_19E6;

    // phase A: 16-bit and 8-bit slots, line 0 drives, receive on line 1
    cfg_line_out = 2'b01;
    st[0] = 2;  wd[0] = 1'b1; en[0] = 1'b1; txw[0] = 16'hA5C3;
    st[1] = 20; wd[1] = 1'b0; en[1] = 1'b1; txw[1] = 16'h03C6;
    st[2] = 10; wd[2] = 1'b1; en[2] = 1'b0; txw[2] = 16'hFFFF;
    run_master(3);

    // phase B: overlapping windows, line 1 drives, receive on line 0
    cfg_line_out = 2'b10;
    pat = 32'h6B1D_F042;
    st[0] = 0;  wd[0] = 1'b1; en[0] = 1'b1; txw[0] = 16'h8E71;
    st[1] = 8;  wd[1] = 1'b0; en[1] = 1'b1; txw[1] = 16'h5A0F;
    st[2] = 24; wd[2] = 1'b0; en[2] = 1'b1; txw[2] = 16'h00D2;
    run_master(3);

    // phase C: both lines drive, no receive line
    cfg_line_out = 2'b11;
    st[0] = 16; wd[0] = 1'b1; en[0] = 1'b1; txw[0] = 16'h3C96;
    en[1] = 1'b0; en[2] = 1'b0;
    run_master(2);

    // phase D: both lines listen
    cfg_line_out = 2'b00;
    pat = 32'h9F30_7AC5;
    st[2] = 23; wd[2] = 1'b0; en[2] = 1'b1; txw[2] = 16'h0077;
    en[0] = 1'b1; st[0] = 4;
    run_master(2);

    // phase E: slave, entry mid-frame with sync low
    cfg_slave = 1'b1;
    slave_phase = 1'b1;
    cfg_line_out = 2'b01;
    pat = 32'h2D7B_E419;
    st[0] = 3;  wd[0] = 1'b1; en[0] = 1'b1; txw[0] = 16'h9E37;
    st[1] = 22; wd[1] = 1'b0; en[1] = 1'b1; txw[1] = 16'h00B4;
    en[2] = 1'b0;
    reset_and_check(1'b0);
    repeat (4) @(negedge clk);
    check(!pcm_clk_oe && !pcm_sync_oe && !pcm_clk_out && !pcm_sync_out, "R11",
          {pcm_clk_oe, pcm_sync_oe, pcm_clk_out, pcm_sync_out}, 0);
    for (int b = 20; b < FRAME; b++) slave_bit(b, -1);
    for (int f = 0; f < 3; f++) begin
      for (int b = 0; b < FRAME; b++) slave_bit(b, f);
      check(rx_sample[15:0] == win(pat, 3, 16, 1'b1), "R11", rx_sample[15:0], win(pat, 3, 16, 1'b1));
      check(rx_sample[31:16] == win(pat, 22, 8, 1'b1), "R11", rx_sample[31:16], win(pat, 22, 8, 1'b1));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule